// File: doc/BRIEF.md
# Four-Channel Gated Tone Detector

This block measures the tone rate on four independent digital line inputs. Each channel produces a per-line seize decision from that rate. A sample strobe clocks one gate counter that all channels share, and that counter sets the measurement window. Each line input is synchronised, and its rising edges are caught in a pending bit. At every strobe, each channel counter adds one if its pending bit is set.

On the last strobe of a window, every channel's count moves into its result register and the counter restarts from zero. The gate reloads in the same update. Each new result is tested against a band around a target tone count. Both seize outputs of a channel (line release and hold-device connect) are asserted when the result falls inside the band and released when it does not. A one-cycle done pulse marks each result update.

Window length, counter width, target count and band half-width are parameters. The defaults are a 10000-strobe window, 16-bit counters and a target of 0x02F5.

Top module: `tone_detector`

## Requirements
- R1: While reset is high and in the first cycle after it, every result, every seize output and the done pulse are zero, and the gate starts a full window.
- R2: A window is exactly GATE_LEN strobes long. Results update on the GATE_LEN-th strobe after reset or after the previous update.
- R3: Each line passes through two synchroniser flops before edge detection. Only rising edges count, and falling edges have no effect. A strobe adds one to a channel counter when at least one rising edge was seen since the previous strobe.
- R4: On the expiry strobe, the result takes the counter value including that strobe's own increment. The counter restarts at zero in the same update, so no edge carries over into the next window.
- R5: A channel counter saturates at its all-ones value instead of wrapping.
- R6: A channel's disconnect and hold outputs are always equal. Both are 1 exactly when the latched result r satisfies TARGET-TOL <= r <= TARGET+TOL, both bounds inclusive.
- R7: done_o is high for the single cycle that follows an expiry strobe.
- R8: Results and seize outputs hold their values in every cycle other than the done cycle.
- R9: Channels are independent: each channel's result depends only on its own line. Result bits [CW*i+CW-1 : CW*i] belong to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Sample strobe, one pulse per sample period |
| line_i | input | NCH | Tone line inputs, asynchronous |
| result_o | output | NCH*CW | Latched edge counts, channel i in bits [CW*i +: CW] |
| disc_o | output | NCH | Per-channel line release (seize) output |
| hold_o | output | NCH | Per-channel hold-device connect output |
| done_o | output | 1 | One-cycle pulse when new results are latched |

## Verification
The bound checker watches the following on every cycle:
- the disconnect and hold outputs of each channel stay equal;
- each seize decision agrees with the band test on the result latched with it;
- results and outputs stay still outside the done cycle;
- done always follows a strobe;
- the number of strobes between updates equals the window length.

The count values themselves come from the bench's scenarios. Those scenarios cover the two band edges and the values just outside them, a channel driven past its counter limit, an idle window after busy ones, and four channels receiving different counts in the same window.

// File: rtl/tone_det_pkg.sv
package tone_det_pkg;

    localparam int DEF_NCH      = 4;
    localparam int DEF_CW       = 16;
    localparam int DEF_GATE_LEN = 10000;
    localparam int DEF_TARGET   = 'h02F5;
    localparam int DEF_TOL      = 8;

    // Strobe event produced by the shared gate.
    typedef struct packed {
        logic tick;    // a sample strobe is being consumed
        logic expire;  // this strobe closes the window
    } gate_evt_t;

    // Inclusive band test around a target count.
    function automatic logic in_band(input int unsigned val,
                                     input int unsigned target,
                                     input int unsigned tol);
        return ((val + tol) >= target) && (val <= (target + tol));
    endfunction

endpackage

// File: rtl/tdet_edge_pend.sv
module tdet_edge_pend #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stb_i,
    input  logic [NCH-1:0] line_i,
    output logic [NCH-1:0] hit_o
);
    logic [NCH-1:0] sync1_q, sync2_q, prev_q, pend_q, rise;

    assign rise  = sync2_q & ~prev_q;
    // An edge seen in the strobe cycle itself is consumed by that strobe.
    assign hit_o = pend_q | rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
            pend_q  <= '0;
        end else begin
            sync1_q <= line_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            pend_q  <= stb_i ? '0 : hit_o;
        end
    end
endmodule

// File: rtl/tdet_gate.sv
module tdet_gate
    import tone_det_pkg::*;
#(
    parameter int GATE_LEN = 10000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stb_i,
    output gate_evt_t evt_o
);
    localparam int GW = (GATE_LEN > 1) ? $clog2(GATE_LEN) : 1;
    localparam logic [GW-1:0] RELOAD = GW'(GATE_LEN - 1);

    logic [GW-1:0] gate_q;

    assign evt_o.tick   = stb_i;
    assign evt_o.expire = stb_i && (gate_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= RELOAD;
        else if (stb_i)
            gate_q <= (gate_q == '0) ? RELOAD : gate_q - 1'b1;
    end
endmodule

// File: rtl/tdet_chan.sv
module tdet_chan
    import tone_det_pkg::*;
#(
    parameter int CW     = 16,
    parameter int TARGET = 'h02F5,
    parameter int TOL    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  gate_evt_t     evt_i,
    input  logic          hit_i,
    output logic [CW-1:0] result_o,
    output logic          det_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q, cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (hit_i && (cnt_q != CNT_MAX))
            cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            result_o <= '0;
            det_o    <= 1'b0;
        end else if (evt_i.tick) begin
            if (evt_i.expire) begin
                result_o <= cnt_nxt;
                det_o    <= in_band(32'(cnt_nxt), TARGET, TOL);
                cnt_q    <= '0;
            end else begin
                cnt_q    <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/tone_detector.sv
module tone_detector
    import tone_det_pkg::*;
#(
    parameter int NCH      = DEF_NCH,
    parameter int CW       = DEF_CW,
    parameter int GATE_LEN = DEF_GATE_LEN,
    parameter int TARGET   = DEF_TARGET,
    parameter int TOL      = DEF_TOL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_stb,
    input  logic [NCH-1:0]    line_i,
    output logic [NCH*CW-1:0] result_o,
    output logic [NCH-1:0]    disc_o,
    output logic [NCH-1:0]    hold_o,
    output logic              done_o
);
    gate_evt_t      evt;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] det;

    tdet_gate #(.GATE_LEN(GATE_LEN)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .stb_i (sample_stb),
        .evt_o (evt)
    );

    tdet_edge_pend #(.NCH(NCH)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (sample_stb),
        .line_i (line_i),
        .hit_o  (hit)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tdet_chan #(.CW(CW), .TARGET(TARGET), .TOL(TOL)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt),
            .hit_i    (hit[i]),
            .result_o (result_o[i*CW +: CW]),
            .det_o    (det[i])
        );
    end

    // Both seize outputs of a line follow one decision.
    assign disc_o = det;
    assign hold_o = det;

    always_ff @(posedge clk) begin
        if (rst) done_o <= 1'b0;
        else     done_o <= evt.expire;
    end
endmodule

// File: rtl/tone_detector_chk.sv
module tone_detector_chk
    import tone_det_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CW       = 16,
    parameter int GATE_LEN = 10000,
    parameter int TARGET   = 'h02F5,
    parameter int TOL      = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_stb,
    input logic [NCH*CW-1:0] result_o,
    input logic [NCH-1:0]    disc_o,
    input logic [NCH-1:0]    hold_o,
    input logic              done_o
);
    int unsigned seen;

    always_ff @(posedge clk) begin
        if (rst)             seen <= 0;
        else if (done_o)     seen <= sample_stb ? 1 : 0;
        else if (sample_stb) seen <= seen + 1;
    end

    // R6
    seize_pair_chk: assert property (@(posedge clk) disable iff (rst)
        disc_o == hold_o);

    for (genvar i = 0; i < NCH; i++) begin : g_band
        // R6
        band_decision_chk: assert property (@(posedge clk) disable iff (rst)
            done_o |-> (disc_o[i] == in_band(32'(result_o[i*CW +: CW]), TARGET, TOL)));
    end

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R8
    seize_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(disc_o));

    // R7
    done_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(sample_stb));

    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (seen == GATE_LEN));
endmodule

bind tone_detector tone_detector_chk #(
    .NCH(NCH), .CW(CW), .GATE_LEN(GATE_LEN), .TARGET(TARGET), .TOL(TOL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .result_o   (result_o),
    .disc_o     (disc_o),
    .hold_o     (hold_o),
    .done_o     (done_o)
);

// File: tb/tone_detector_test.sv
`timescale 1ns/1ps
module tone_detector_test;
    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int L   = 300;
    localparam int TGT = 100;
    localparam int TOL = 3;

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] res;
        logic [NCH-1:0]         det;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_stb = 1'b0;
    logic [NCH-1:0]    line_i = '0;
    logic [NCH*CW-1:0] result_o;
    logic [NCH-1:0]    disc_o, hold_o;
    logic              done_o;

    int   n_vec = 0;
    int   n_bad = 0;
    int   stb_total = 0;
    int   stb_base = 0;
    bit   finished = 0;
    exp_t expq[$];
    exp_t last_exp = '0;

    always #4 clk = ~clk;

    tone_detector #(.NCH(NCH), .CW(CW), .GATE_LEN(L), .TARGET(TGT), .TOL(TOL)) uut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .line_i(line_i),
        .result_o(result_o), .disc_o(disc_o), .hold_o(hold_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) if (!rst && sample_stb) stb_total++;

    // One window: channel c pulses its line in slots 1..n[c].
    task automatic run_window(input int n0, input int n1, input int n2, input int n3);
        int   n[NCH];
        exp_t e;
        n[0] = n0; n[1] = n1; n[2] = n2; n[3] = n3;
        for (int c = 0; c < NCH; c++) begin
            int v;
            v = (n[c] > 255) ? 255 : n[c];
            e.res[c] = CW'(v);
            e.det[c] = (v >= TGT - TOL) && (v <= TGT + TOL);
        end
        expq.push_back(e);
        for (int s = 1; s <= L; s++) begin
            @(negedge clk);
            sample_stb = 1'b1;
            for (int c = 0; c < NCH; c++) line_i[c] = (s <= n[c]);
            @(negedge clk);
            sample_stb = 1'b0;
            @(negedge clk);
            line_i = '0;
            @(negedge clk);
        end
    endtask

    // Monitor: pops expectations on each done pulse.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done_o) begin
                if (expq.size() == 0) begin
                    check("R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    last_exp = e;
                    // R2: strobes since previous update
                    check("R2 window length", stb_total - stb_base, L);
                    stb_base = stb_total;
                    for (int c = 0; c < NCH; c++) begin
                        // R3 R4 R5 R9 counts per channel
                        check($sformatf("R4 result ch%0d", c),
                              int'(result_o[c*CW +: CW]), int'(e.res[c]));
                        check($sformatf("R6 disc ch%0d", c), int'(disc_o[c]), int'(e.det[c]));
                        check($sformatf("R6 hold ch%0d", c), int'(hold_o[c]), int'(e.det[c]));
                    end
                end
            end else if (result_o != last_exp.res || disc_o != last_exp.det) begin
                // R8: nothing moves outside the done cycle
                check("R8 result held", int'(result_o), int'(last_exp.res));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 result in reset", int'(result_o), 0);
        check("R1 seize in reset", int'({disc_o, hold_o}), 0);
        check("R1 done in reset", int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after reset", int'(result_o), 0);
        check("R1 seize after reset", int'({disc_o, hold_o}), 0);
        // R6 band edges, R9 independent channels, R3 pulses (falling edges ignored)
        run_window(100, 97, 103, 0);
        // R6 just outside band, R5 saturation
        run_window(96, 104, 290, 5);
        // R4 counter cleared: idle window
        run_window(0, 0, 0, 0);
        // R5 exact max not saturated, mixed decisions
        run_window(101, 99, 255, 100);
        repeat (8) @(negedge clk);
        // R7 every expected update was seen
        check("R7 pending updates", expq.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule